// File: doc/BRIEF.md
# Rounding Add High-Half Narrowing Vector Datapath

This block takes two 128-bit vectors, each packed with wide integer lanes, and returns one 64-bit vector of narrow lanes. For every lane it adds the two wide elements together with a rounding constant. That constant is half the weight of one narrow unit. The block then keeps the upper half of the wrapped sum, so each narrow result is the rounded high half of the wide sum rather than a truncated one. The arithmetic is the same for signed and unsigned data, so the block has no signedness input and produces no flags beyond a reserved-size indication.

A 2-bit size code selects the lane width at run time. Code 0 selects 16-bit wide lanes, code 1 selects 32-bit lanes and code 2 selects 64-bit lanes. All three lane widths are computed in parallel and a final multiplexer picks one. The result is captured in an output register stage whenever the valid input is high, so it appears one cycle later with a matching valid flag. A build parameter can remove that register stage.

Top module: `rnd_add_hi_narrow`

## Requirements
- R1: With size code 0, each 8-bit result lane e holds bits [15:8] of (a_e + b_e + 0x80) mod 2^16, where a_e and b_e are the 16-bit source lanes at bits [16e +: 16].
- R2: With size code 1, each 16-bit result lane holds bits [31:16] of (a_e + b_e + 0x8000) mod 2^32, where a_e and b_e are the 32-bit source lanes.
- R3: With size code 2, each 32-bit result lane holds bits [63:32] of (a_e + b_e + 2^31) mod 2^64, where a_e and b_e are the 64-bit source lanes.
- R4: A carry out of the top bit of a wide lane is discarded. For example, two all-ones 16-bit elements give the narrow result 0x00, and carries never cross into a neighbouring lane.
- R5: Narrow lane e occupies result bits [e*esize +: esize], with lane 0 in the least significant bits.
- R6: Size code 3 is reserved. It produces a result of zero and sets size_illegal to 1. Legal codes clear size_illegal.
- R7: out_valid equals in_valid delayed by exactly one clock cycle.
- R8: While in_valid is low, result and size_illegal keep their previous values regardless of the operands and the size code.
- R9: After reset, out_valid, result and size_illegal are all zero.
- R10: When the low half of a wide sum equals the rounding constant exactly, the high half is incremented, which is round half up. The rounding carry also propagates through an all-ones low half into the high half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and size code are valid this cycle |
| size_sel | input | 2 | Wide lane width: 0 = 16, 1 = 32, 2 = 64 bits, 3 = reserved |
| src_a | input | 128 | First vector of wide elements |
| src_b | input | 128 | Second vector of wide elements |
| out_valid | output | 1 | Result is valid (in_valid delayed one cycle) |
| result | output | 64 | Packed narrow rounded high halves |
| size_illegal | output | 1 | Reserved size code was used for the held result |

## Verification
The bound checker watches the properties that hold on every cycle: the one-cycle valid delay, the holding of the result and flag while idle, the zero result under the reserved code, the illegal flag against the registered size code, and the lowest narrow lane of the 16-bit mode. The full lane arithmetic for every width is shown only by the bench's directed scenarios, which compare against an independent model. So are the lane placement, the wrap of all-ones sums, the exact rounding tie and a carry rippling through the low half.

// File: rtl/rhn_pkg.sv
package rhn_pkg;
   localparam int unsigned SRC_W       = 128;
   localparam int unsigned DST_W       = 64;
   localparam int unsigned MIN_WIDE_W  = 16;
   localparam int unsigned NUM_SIZES   = 3;
   localparam int unsigned SZ_W        = 2;

   typedef enum logic [SZ_W-1:0] {
      SZ_WIDE16 = 2'd0,
      SZ_WIDE32 = 2'd1,
      SZ_WIDE64 = 2'd2,
      SZ_RSVD   = 2'd3
   } lane_size_e;

   function automatic int unsigned wide_width(input int unsigned idx);
      return MIN_WIDE_W << idx;
   endfunction
endpackage

// File: rtl/rhn_lane.sv
module rhn_lane #(
   parameter int unsigned WIDE_W = 16
) (
   input  logic [WIDE_W-1:0]   wide_a,
   input  logic [WIDE_W-1:0]   wide_b,
   output logic [WIDE_W/2-1:0] narrow_y
);
   localparam int unsigned NAR_W = WIDE_W / 2;
   localparam logic [WIDE_W-1:0] ROUND_K = WIDE_W'(1) << (NAR_W - 1);

   if (WIDE_W < 2 || (WIDE_W % 2) != 0) begin : g_bad_w
      $error("rhn_lane: WIDE_W must be even and at least 2");
   end

   logic [WIDE_W-1:0] wrap_sum;

   always_comb begin
      wrap_sum = wide_a + wide_b + ROUND_K;
      narrow_y = wrap_sum[WIDE_W-1:NAR_W];
   end
endmodule

// File: rtl/rhn_width_slice.sv
module rhn_width_slice #(
   parameter int unsigned VEC_W  = 128,
   parameter int unsigned WIDE_W = 16
) (
   input  logic [VEC_W-1:0]   vec_a,
   input  logic [VEC_W-1:0]   vec_b,
   output logic [VEC_W/2-1:0] vec_y
);
   localparam int unsigned NAR_W  = WIDE_W / 2;
   localparam int unsigned LANES  = VEC_W / WIDE_W;

   if ((VEC_W % WIDE_W) != 0) begin : g_bad_split
      $error("rhn_width_slice: VEC_W must be a multiple of WIDE_W");
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      rhn_lane #(.WIDE_W(WIDE_W)) u_lane (
         .wide_a  (vec_a[l*WIDE_W +: WIDE_W]),
         .wide_b  (vec_b[l*WIDE_W +: WIDE_W]),
         .narrow_y(vec_y[l*NAR_W  +: NAR_W])
      );
   end
endmodule

// File: rtl/rhn_out_stage.sv
module rhn_out_stage #(
   parameter int unsigned W         = 64,
   parameter bit          REGISTERED = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         d_valid,
   input  logic [W-1:0] d_res,
   input  logic         d_ill,
   output logic         q_valid,
   output logic [W-1:0] q_res,
   output logic         q_ill
);
   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q_valid <= 1'b0;
            q_res   <= '0;
            q_ill   <= 1'b0;
         end else begin
            q_valid <= d_valid;
            if (d_valid) begin
               q_res <= d_res;
               q_ill <= d_ill;
            end
         end
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign q_valid = d_valid;
      assign q_res   = d_res;
      assign q_ill   = d_ill;
   end
endmodule

// File: rtl/rnd_add_hi_narrow.sv
module rnd_add_hi_narrow
   import rhn_pkg::*;
#(
   parameter int unsigned VEC_W   = SRC_W,
   parameter int unsigned RES_W   = DST_W,
   parameter int unsigned N_SIZES = NUM_SIZES,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [SZ_W-1:0]  size_sel,
   input  logic [VEC_W-1:0] src_a,
   input  logic [VEC_W-1:0] src_b,
   output logic             out_valid,
   output logic [RES_W-1:0] result,
   output logic             size_illegal
);
   if (RES_W * 2 != VEC_W) begin : g_bad_ratio
      $error("rnd_add_hi_narrow: RES_W must be half of VEC_W");
   end
   if (N_SIZES < 1 || N_SIZES >= (1 << SZ_W)) begin : g_bad_sizes
      $error("rnd_add_hi_narrow: N_SIZES must leave one reserved code");
   end
   if ((MIN_WIDE_W << (N_SIZES - 1)) > VEC_W) begin : g_bad_widest
      $error("rnd_add_hi_narrow: widest lane exceeds the vector");
   end

   logic [RES_W-1:0] slice_y [N_SIZES];
   logic [RES_W-1:0] sel_y;
   logic             sel_ill;

   for (genvar s = 0; s < N_SIZES; s++) begin : g_size
      rhn_width_slice #(
         .VEC_W (VEC_W),
         .WIDE_W(wide_width(s))
      ) u_slice (
         .vec_a(src_a),
         .vec_b(src_b),
         .vec_y(slice_y[s])
      );
   end

   always_comb begin
      sel_y   = '0;
      sel_ill = 1'b1;
      for (int s = 0; s < N_SIZES; s++) begin
         if (size_sel == SZ_W'(s)) begin
            sel_y   = slice_y[s];
            sel_ill = 1'b0;
         end
      end
   end

   rhn_out_stage #(
      .W         (RES_W),
      .REGISTERED(REG_OUT)
   ) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_valid(in_valid),
      .d_res  (sel_y),
      .d_ill  (sel_ill),
      .q_valid(out_valid),
      .q_res  (result),
      .q_ill  (size_illegal)
   );
endmodule

// File: rtl/rhn_checker.sv
module rhn_checker #(
   parameter int unsigned VEC_W   = 128,
   parameter int unsigned RES_W   = 64,
   parameter bit          REG_OUT = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [1:0]       size_sel,
   input logic [VEC_W-1:0] src_a,
   input logic [VEC_W-1:0] src_b,
   input logic             out_valid,
   input logic [RES_W-1:0] result,
   input logic             size_illegal
);
   logic [15:0] low_lane_sum;
   assign low_lane_sum = src_a[15:0] + src_b[15:0] + 16'h0080;

   if (REG_OUT) begin : g_seq
      a_r7_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      a_r7_idle_delay: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);
      a_r8_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> ($stable(result) && $stable(size_illegal)));
      a_r6_flag_code: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> (size_illegal == ($past(size_sel) == 2'd3)));
      a_r1_low_lane: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && size_sel == 2'd0) |=> (result[7:0] == $past(low_lane_sum[15:8])));
   end

   a_r6_zero_result: assert property (@(posedge clk) disable iff (!rst_n)
      size_illegal |-> (result == '0));
endmodule

bind rnd_add_hi_narrow rhn_checker #(
   .VEC_W  (VEC_W),
   .RES_W  (RES_W),
   .REG_OUT(REG_OUT)
) u_rhn_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .size_sel    (size_sel),
   .src_a       (src_a),
   .src_b       (src_b),
   .out_valid   (out_valid),
   .result      (result),
   .size_illegal(size_illegal)
);

// File: tb/tb_rnd_add_hi_narrow.sv
module tb_rnd_add_hi_narrow;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [1:0]   size_sel = 2'd0;
   logic [127:0] src_a = '0;
   logic [127:0] src_b = '0;
   logic         out_valid;
   logic [63:0]  result;
   logic         size_illegal;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   rnd_add_hi_narrow dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size_sel(size_sel),
      .src_a(src_a), .src_b(src_b), .out_valid(out_valid),
      .result(result), .size_illegal(size_illegal)
   );

   function automatic logic [63:0] model(input logic [127:0] a, input logic [127:0] b,
                                         input logic [1:0] sz);
      logic [127:0] acc;
      logic [127:0] m2;
      logic [127:0] mn;
      logic [127:0] wa;
      logic [127:0] wb;
      logic [127:0] s;
      int es;
      if (sz == 2'd3) return 64'd0;
      es  = 8 << sz;
      m2  = (128'd1 << (2*es)) - 128'd1;
      mn  = (128'd1 << es) - 128'd1;
      acc = '0;
      for (int e = 0; e < 64/es; e++) begin
         wa  = (a >> (e*2*es)) & m2;
         wb  = (b >> (e*2*es)) & m2;
         s   = (wa + wb + (128'd1 << (es-1))) & m2;
         acc = acc | (((s >> es) & mn) << (e*es));
      end
      return acc[63:0];
   endfunction

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   endtask

   // drive at negedge, one valid cycle, result visible at following negedge
   task automatic apply(input logic [127:0] a, input logic [127:0] b, input logic [1:0] sz);
      @(negedge clk);
      src_a = a; src_b = b; size_sel = sz; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic t_reset();
      check("R9 out_valid", {63'd0, out_valid}, 64'd0);
      check("R9 result", result, 64'd0);
      check("R9 illegal", {63'd0, size_illegal}, 64'd0);
   endtask

   task automatic t_mode(input logic [1:0] sz, input string req);
      logic [127:0] a;
      logic [127:0] b;
      for (int k = 0; k < 4; k++) begin
         a = {$urandom, $urandom, $urandom, $urandom};
         b = {$urandom, $urandom, $urandom, $urandom};
         apply(a, b, sz);
         check(req, result, model(a, b, sz));
         check({req, " legal flag"}, {63'd0, size_illegal}, 64'd0);
      end
   endtask

   task automatic t_all_ones();
      apply({128{1'b1}}, {128{1'b1}}, 2'd0);
      check("R4 ones16", result, 64'h0000_0000_0000_0000);
      apply({128{1'b1}}, {128{1'b1}}, 2'd1);
      check("R4 ones32", result, model({128{1'b1}}, {128{1'b1}}, 2'd1));
      apply({128{1'b1}}, {128{1'b1}}, 2'd2);
      check("R4 ones64", result, model({128{1'b1}}, {128{1'b1}}, 2'd2));
      // lane 0 wraps to 0xFFFF+1; lane 1 must be untouched by that carry
      apply({112'd0, 16'hFFFF}, {112'd0, 16'h0001}, 2'd0);
      check("R4 no cross-lane carry", result, 64'h0000_0000_0000_0000);
   endtask

   task automatic t_rounding();
      apply({112'd0, 16'h1280}, 128'd0, 2'd0);
      check("R10 tie 16", result, 64'h0000_0000_0000_0013);
      apply({112'd0, 16'h127F}, 128'd0, 2'd0);
      check("R10 below tie 16", result, 64'h0000_0000_0000_0012);
      apply({64'd0, 64'h0000_0005_7FFF_FFFF}, {64'd0, 64'h0000_0000_0000_0001}, 2'd2);
      check("R10 tie 64", result, 64'h0000_0000_0000_0006);
      apply({96'd0, 32'h00FF_FFFF}, 128'd0, 2'd1);
      check("R10 ripple 32", result, 64'h0000_0000_0000_0100);
   endtask

   task automatic t_lane_order();
      logic [127:0] a;
      a = '0;
      for (int e = 0; e < 8; e++) a[e*16 +: 16] = {8'(e + 1), 8'h00};
      apply(a, 128'd0, 2'd0);
      check("R5 order16", result, 64'h0807_0605_0403_0201);
      apply({32'h0004_0000, 32'h0003_0000, 32'h0002_0000, 32'h0001_0000}, 128'd0, 2'd1);
      check("R5 order32", result, 64'h0004_0003_0002_0001);
   endtask

   task automatic t_reserved();
      apply({128{1'b1}}, 128'h1234, 2'd3);
      check("R6 zero", result, 64'd0);
      check("R6 flag", {63'd0, size_illegal}, 64'd1);
      apply(128'h1_0000, 128'd0, 2'd1);
      check("R6 flag clears", {63'd0, size_illegal}, 64'd0);
   endtask

   task automatic t_valid_and_hold();
      logic [63:0] held;
      @(negedge clk);
      src_a = {4{32'hA5A5_5A5A}}; src_b = {4{32'h0F0F_F0F0}}; size_sel = 2'd1; in_valid = 1'b1;
      @(negedge clk);
      check("R7 valid high", {63'd0, out_valid}, 64'd1);
      held = result;
      in_valid = 1'b0; size_sel = 2'd3; src_a = '1; src_b = 128'h77;
      @(negedge clk);
      check("R7 valid low", {63'd0, out_valid}, 64'd0);
      check("R8 hold result", result, held);
      size_sel = 2'd0; src_a = 128'h55;
      @(negedge clk);
      check("R8 hold result 2", result, held);
      check("R8 hold flag", {63'd0, size_illegal}, 64'd0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      #5;
      t_reset();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mode(2'd0, "R1 mode16");
      t_mode(2'd1, "R2 mode32");
      t_mode(2'd2, "R3 mode64");
      t_all_ones();
      t_rounding();
      t_lane_order();
      t_reserved();
      t_valid_and_hold();
      finish_run();
   end
endmodule